// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block carries single-byte program and data transfers from an internal requester out to external memory over a narrow multiplexed bus. One 8-bit port carries the low address byte first and then the data byte. A second port carries the high address byte for the whole transfer. An address strobe (`as_n_o`) is pulsed low at the start of each transfer, and the external latch captures the low address on its rising edge. After the shared port has been released, a data strobe (`ds_n_o`) frames the data phase. The direction line `rw_o` is high for a read and low for a write.

The requester presents an address, a write flag, write data and an extended-timing flag, qualified by `req_valid`. A request is taken only while `req_ready` is high, which is the case only when the controller is idle. Read data appears on `rsp_rdata` and stays there, and `rsp_done` pulses once in the last cycle of each transfer. Extended timing stretches the data strobe and adds two clock periods to the transfer.

A float input removes every bus driver at once: the shared port, the high address port, and the three control lines. The internal sequence keeps running while the bus floats. Pads are modelled as value and output-enable pairs, and the shared port has its own input.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, `req_ready`=1, `as_n_o`=1, `ds_n_o`=1, `rw_o`=1, `rsp_done`=0, `ad_oe`=0, `ahi_oe`=0 and `ctl_oe`=1.
- R2: A request is taken at a clock edge where `req_valid`=1 and `req_ready`=1. Cycle T1 is the cycle after that edge. `req_ready` is 0 from T1 through the done cycle, and request inputs seen in that window have no effect on the running transfer.
- R3: `as_n_o` is 0 in T1 only. In T1, `ad_oe`=1 with `ad_o` equal to address bits [7:0], and `ahi_o` carries address bits [15:8] throughout the transfer.
- R4: `rw_o` is 1 for a read and 0 for a write. It is constant from T1 through the done cycle, and it is 1 when idle.
- R5: On a read, `ad_oe`=0 from T2 onward, and `ds_n_o` is 0 in T3 and T4. `ad_in` is sampled at the clock edge ending the last strobe-low cycle and is held on `rsp_rdata` from the done cycle until the next read completes.
- R6: On a write, `ds_n_o` is 0 in T4 only, which is one cycle shorter than a read. `ad_oe` is 0 in T2, and `ad_o` carries the write data with `ad_oe`=1 from T3 through the done cycle.
- R7: With the extended flag set, the transfer lasts 7 cycles instead of 5. The strobe-low window ends in T6 instead of T4, and its start is unchanged.
- R8: `rsp_done` is 1 for exactly one cycle: T5 for normal timing and T7 for extended timing. The controller is idle with `req_ready`=1 in the following cycle.
- R9: While `bus_float`=1, `ad_oe`, `ahi_oe` and `ctl_oe` are all 0. The strobe timing, `rsp_done` and read sampling follow the same cycles as in R5–R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_addr | input | 16 | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| req_ext | input | 1 | Extended timing (+2 cycles) |
| bus_float | input | 1 | Release all bus drivers |
| rsp_done | output | 1 | One-cycle transfer completion |
| rsp_rdata | output | 8 | Last read data |
| ad_o | output | 8 | Shared address/data port value |
| ad_oe | output | 1 | Shared port output enable |
| ad_in | input | 8 | Shared port input |
| ahi_o | output | 8 | High address port value |
| ahi_oe | output | 1 | High address port output enable |
| as_n_o | output | 1 | Address strobe, active low |
| ds_n_o | output | 1 | Data strobe, active low |
| rw_o | output | 1 | Direction, 1 = read |
| ctl_oe | output | 1 | Output enable for the three control lines |

## Verification
Every strobe, enable and port value derives from one cycle counter, so a wrong count shows at the ports in the same cycle. It appears as a misplaced `as_n_o` or `ds_n_o` edge, as `ad_oe` rising during a read's strobe window, or as `rsp_done` arriving early or late. A wrong capture edge shows as soon as the read completes, because the bench drives `ad_in` with the expected byte only in strobe-low cycles. A stale busy flag shows in the cycle after the done pulse, as `req_ready` held low. A float gate that misses a driver shows in any cycle of a floated transfer.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  // Cycle count of a transfer with normal timing.
  localparam int XB_BASE_LEN = 5;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_GAP,
    PH_DATA
  } xb_phase_e;

  // Transfer length in cycles.
  function automatic int xb_len(input bit ext, input int extra);
    return XB_BASE_LEN + (ext ? extra : 0);
  endfunction

  // First cycle with the data strobe low.
  function automatic int xb_ds_first(input bit wr);
    return wr ? 4 : 3;
  endfunction

  // Data strobe low in cycle k of a transfer.
  function automatic bit xb_ds_low(input int k, input bit wr, input bit ext,
                                   input int extra);
    return (k >= xb_ds_first(wr)) && (k <= xb_len(ext, extra) - 1);
  endfunction

endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int DW         = 8,
  parameter int AHW        = 8,
  parameter int EXT_CYCLES = 2,
  localparam int AW        = DW + AHW,
  localparam int CW        = $clog2(XB_BASE_LEN + EXT_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_ext,
  output logic          busy,
  output logic [CW-1:0] cyc,
  output logic [AW-1:0] addr_q,
  output logic          wr_q,
  output logic [DW-1:0] wd_q,
  output logic          ext_q
);

  logic accept;
  logic end_now;

  assign req_ready = !busy;
  assign accept    = req_valid && !busy;
  assign end_now   = busy && (int'(cyc) == xb_len(ext_q, EXT_CYCLES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cyc    <= '0;
      addr_q <= '0;
      wr_q   <= 1'b0;
      wd_q   <= '0;
      ext_q  <= 1'b0;
    end else if (accept) begin
      busy   <= 1'b1;
      cyc    <= CW'(1);
      addr_q <= req_addr;
      wr_q   <= req_write;
      wd_q   <= req_wdata;
      ext_q  <= req_ext;
    end else if (end_now) begin
      busy <= 1'b0;
      cyc  <= '0;
    end else if (busy) begin
      cyc <= cyc + CW'(1);
    end
  end

  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && (cyc == CW'(1)) && !req_ready); // R2

  AST_CYC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cyc != '0) && (int'(cyc) <= xb_len(ext_q, EXT_CYCLES))); // R7

endmodule

// File: rtl/xbus_phase.sv
module xbus_phase
  import xbus_pkg::*;
#(
  parameter int EXT_CYCLES = 2,
  localparam int CW        = $clog2(XB_BASE_LEN + EXT_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic [CW-1:0] cyc,
  input  logic          wr_q,
  input  logic          ext_q,
  output xb_phase_e     phase,
  output logic          as_act,
  output logic          ds_act,
  output logic          sample_now,
  output logic          done
);

  int k;
  int len;

  always_comb begin
    k   = int'(cyc);
    len = xb_len(ext_q, EXT_CYCLES);
    if (!busy)       phase = PH_IDLE;
    else if (k == 1) phase = PH_ADDR;
    else if (k == 2) phase = PH_GAP;
    else             phase = PH_DATA;
  end

  assign as_act     = (phase == PH_ADDR);
  assign ds_act     = busy && xb_ds_low(k, wr_q, ext_q, EXT_CYCLES);
  assign sample_now = busy && !wr_q && (k == len - 1);
  assign done       = busy && (k == len);

  AST_AS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    as_act |=> !as_act); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R8

  AST_DS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    ds_act |-> !as_act && (phase == PH_DATA)); // R5

endmodule

// File: rtl/xbus_pads.sv
module xbus_pads
  import xbus_pkg::*;
#(
  parameter int DW  = 8,
  parameter int AHW = 8,
  localparam int AW = DW + AHW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_float,
  input  logic          busy,
  input  xb_phase_e     phase,
  input  logic          as_act,
  input  logic          ds_act,
  input  logic          sample_now,
  input  logic          wr_q,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] wd_q,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  output logic [AHW-1:0] ahi_o,
  output logic          ahi_oe,
  output logic          as_n_o,
  output logic          ds_n_o,
  output logic          rw_o,
  output logic          ctl_oe,
  output logic [DW-1:0] rsp_rdata
);

  logic drive_ad;

  assign drive_ad = (phase == PH_ADDR) || (wr_q && (phase == PH_DATA));

  assign ad_o   = (phase == PH_ADDR) ? addr_q[DW-1:0] : wd_q;
  assign ad_oe  = !bus_float && drive_ad;
  assign ahi_o  = addr_q[AW-1:DW];
  assign ahi_oe = !bus_float && busy;
  assign as_n_o = !as_act;
  assign ds_n_o = !ds_act;
  assign rw_o   = busy ? !wr_q : 1'b1;
  assign ctl_oe = !bus_float;

  always_ff @(posedge clk) begin
    if (!rst_n)          rsp_rdata <= '0;
    else if (sample_now) rsp_rdata <= ad_in;
  end

  AST_RW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(rw_o)); // R4

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_act && $past(ds_act) && wr_q && !bus_float) |-> ad_oe); // R6

  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_act && !wr_q) |-> !ad_oe); // R5

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int DW         = 8,
  parameter int AHW        = 8,
  parameter int EXT_CYCLES = 2,
  localparam int AW        = DW + AHW,
  localparam int CW        = $clog2(XB_BASE_LEN + EXT_CYCLES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [AW-1:0]  req_addr,
  input  logic           req_write,
  input  logic [DW-1:0]  req_wdata,
  input  logic           req_ext,
  input  logic           bus_float,
  output logic           rsp_done,
  output logic [DW-1:0]  rsp_rdata,
  output logic [DW-1:0]  ad_o,
  output logic           ad_oe,
  input  logic [DW-1:0]  ad_in,
  output logic [AHW-1:0] ahi_o,
  output logic           ahi_oe,
  output logic           as_n_o,
  output logic           ds_n_o,
  output logic           rw_o,
  output logic           ctl_oe
);

  logic          busy;
  logic [CW-1:0] cyc;
  logic [AW-1:0] addr_q;
  logic          wr_q;
  logic [DW-1:0] wd_q;
  logic          ext_q;
  xb_phase_e     phase;
  logic          as_act;
  logic          ds_act;
  logic          sample_now;

  xbus_seq #(.DW(DW), .AHW(AHW), .EXT_CYCLES(EXT_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .req_ext   (req_ext),
    .busy      (busy),
    .cyc       (cyc),
    .addr_q    (addr_q),
    .wr_q      (wr_q),
    .wd_q      (wd_q),
    .ext_q     (ext_q)
  );

  xbus_phase #(.EXT_CYCLES(EXT_CYCLES)) u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .cyc        (cyc),
    .wr_q       (wr_q),
    .ext_q      (ext_q),
    .phase      (phase),
    .as_act     (as_act),
    .ds_act     (ds_act),
    .sample_now (sample_now),
    .done       (rsp_done)
  );

  xbus_pads #(.DW(DW), .AHW(AHW)) u_pads (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_float  (bus_float),
    .busy       (busy),
    .phase      (phase),
    .as_act     (as_act),
    .ds_act     (ds_act),
    .sample_now (sample_now),
    .wr_q       (wr_q),
    .addr_q     (addr_q),
    .wd_q       (wd_q),
    .ad_in      (ad_in),
    .ad_o       (ad_o),
    .ad_oe      (ad_oe),
    .ahi_o      (ahi_o),
    .ahi_oe     (ahi_oe),
    .as_n_o     (as_n_o),
    .ds_n_o     (ds_n_o),
    .rw_o       (rw_o),
    .ctl_oe     (ctl_oe),
    .rsp_rdata  (rsp_rdata)
  );

  AST_FLOAT_HOLDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_float && !as_n_o) |=> as_n_o && !req_ready); // R9

endmodule

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_wdata = '0;
  logic        req_ext = 1'b0;
  logic        bus_float = 1'b0;
  logic        rsp_done;
  logic [7:0]  rsp_rdata;
  logic [7:0]  ad_o;
  logic        ad_oe;
  logic [7:0]  ad_in = 8'hEE;
  logic [7:0]  ahi_o;
  logic        ahi_oe;
  logic        as_n_o;
  logic        ds_n_o;
  logic        rw_o;
  logic        ctl_oe;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] last_rd = 8'h00;

  always #2.5 clk = ~clk;

  xbus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_ext(req_ext), .bus_float(bus_float), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .ad_o(ad_o), .ad_oe(ad_oe), .ad_in(ad_in),
    .ahi_o(ahi_o), .ahi_oe(ahi_oe), .as_n_o(as_n_o), .ds_n_o(ds_n_o),
    .rw_o(rw_o), .ctl_oe(ctl_oe)
  );

  function automatic logic [7:0] mem_val(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  function automatic int exp_len(input bit ext);
    return ext ? 7 : 5;
  endfunction

  function automatic bit exp_ds_low(input int k, input bit wr, input bit ext);
    int first;
    first = wr ? 4 : 3;
    return (k >= first) && (k < exp_len(ext));
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic xfer(input logic [15:0] a, input bit wr, input logic [7:0] wd,
                      input bit ext, input bit flt, input bit poke);
    int L;
    L = exp_len(ext);
    @(negedge clk);
    req_addr  = a;
    req_write = wr;
    req_wdata = wd;
    req_ext   = ext;
    bus_float = flt;
    req_valid = 1'b1;
    ad_in     = 8'hEE;
    check(req_ready == 1'b1, "R2 ready when idle", 32'(req_ready), 32'd1);
    @(posedge clk); #2;
    if (poke) begin
      req_addr  = ~a;
      req_write = ~wr;
      req_ext   = ~ext;
      req_wdata = ~wd;
    end else begin
      req_valid = 1'b0;
    end
    for (int k = 1; k <= L; k++) begin
      bit dsl;
      bit exp_oe;
      dsl = exp_ds_low(k, wr, ext);
      ad_in = dsl ? mem_val(a) : 8'hEE;
      check(as_n_o == (k != 1), "R3 as_n", 32'(as_n_o), 32'(k != 1));
      check(ds_n_o == !dsl, ext ? "R7 ds_n ext" : (wr ? "R6 ds_n" : "R5 ds_n"),
            32'(ds_n_o), 32'(!dsl));
      check(rw_o == !wr, "R4 rw", 32'(rw_o), 32'(!wr));
      check(req_ready == 1'b0, "R2 ready low busy", 32'(req_ready), 32'd0);
      check(rsp_done == (k == L), "R8 done", 32'(rsp_done), 32'(k == L));
      exp_oe = !flt && ((k == 1) || (wr && k >= 3));
      check(ad_oe == exp_oe, flt ? "R9 ad_oe float" : "R6 ad_oe", 32'(ad_oe),
            32'(exp_oe));
      if (k == 1 && !flt)
        check(ad_o == a[7:0], "R3 low address", 32'(ad_o), 32'(a[7:0]));
      if (wr && k >= 3 && !flt)
        check(ad_o == wd, "R6 write data", 32'(ad_o), 32'(wd));
      check(ahi_oe == !flt && ctl_oe == !flt, "R9 oe gating",
            {30'd0, ahi_oe, ctl_oe}, {30'd0, !flt, !flt});
      if (!flt)
        check(ahi_o == a[15:8], "R3 high address", 32'(ahi_o), 32'(a[15:8]));
      if (k == L) begin
        if (!wr) begin
          last_rd = mem_val(a);
          check(rsp_rdata == last_rd, "R5 read data", 32'(rsp_rdata),
                32'(last_rd));
        end
        req_valid = 1'b0;
      end
      @(posedge clk); #2;
    end
    check(req_ready == 1'b1 && rsp_done == 1'b0 && as_n_o == 1'b1,
          "R8 idle after done", {29'd0, req_ready, rsp_done, as_n_o}, 32'h5);
    check(rw_o == 1'b1, "R4 rw idle", 32'(rw_o), 32'd1);
    check(rsp_rdata == last_rd, "R5 read data held", 32'(rsp_rdata),
          32'(last_rd));
    bus_float = 1'b0;
  endtask

  initial begin
    int cnt = 0;
    while (cnt < 100000) begin
      @(posedge clk);
      cnt++;
    end
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h1357));
    repeat (3) @(posedge clk);
    #2;
    check(req_ready == 1'b1 && as_n_o == 1'b1 && ds_n_o == 1'b1 && rw_o == 1'b1,
          "R1 reset strobes", {28'd0, req_ready, as_n_o, ds_n_o, rw_o}, 32'hF);
    check(rsp_done == 1'b0 && ad_oe == 1'b0 && ahi_oe == 1'b0 && ctl_oe == 1'b1,
          "R1 reset enables", {28'd0, rsp_done, ad_oe, ahi_oe, ctl_oe}, 32'h1);
    @(negedge clk);
    rst_n = 1'b1;

    xfer(16'h12C4, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    xfer(16'hA53C, 1'b1, 8'h96, 1'b0, 1'b0, 1'b0);
    xfer(16'h0FF0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
    xfer(16'hFFFF, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b0);
    xfer(16'h4411, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
    xfer(16'h8001, 1'b1, 8'h7E, 1'b1, 1'b1, 1'b0);
    xfer(16'h0000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    xfer(16'hBEEF, 1'b1, 8'hC3, 1'b0, 1'b0, 1'b1);

    for (int i = 0; i < 60; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      logic [3:0]  r;
      a = 16'($urandom);
      d = 8'($urandom);
      r = 4'($urandom);
      xfer(a, r[0], d, r[1], (r[3:2] == 2'b11), r[2] & ~r[3]);
      if (r[3]) repeat (int'(r[1:0])) @(posedge clk);
    end

    finish_run();
  end

endmodule